// File: doc/BRIEF.md
# Receive-Only Byte Request Controller

This block runs the receive-only side of a serial master. Software writes a byte count through a simple register port. While bytes remain to be received, the block asks the shift engine for serial clocking. The engine hands back one received byte per strobe. The block packs those bytes into 32-bit words and pushes each completed word into a receive FIFO. A readable down-counter shows how many requested bytes are still outstanding.

In this mode the word width is fixed at four bytes, whatever width the serial side might otherwise use. A request whose length is not a multiple of four ends with a short word. A status field reports how many bytes of the most recently completed word are valid. That lets software unpack the tail correctly. Long receives are split into chunks: once one request has finished and its data has been drained, a new count is written.

During clocking the serial output follows a static idle level, so no transmit data is required. If a word completes while the FIFO is full, the word is dropped and a sticky overflow flag is raised.

Top module: `rxo_req_ctl`

## Requirements
- R1: After reset, `todo_o` is 0, and `run_o`, `done_o` and `push_o` are low. `status_o` is all zero.
- R2: A write of count N with `todo_o` at 0 loads `todo_o` with N by the next cycle. `run_o` is high exactly while `todo_o` is non-zero, so a count of 0 starts nothing.
- R3: Each `byte_vld_i` strobe accepted while `todo_o` is non-zero lowers `todo_o` by one in the next cycle. When the last byte is taken, `run_o` falls and `done_o` pulses for one cycle in the next cycle. Strobes that arrive while `todo_o` is 0 change nothing and push nothing.
- R4: Every four accepted bytes form one pushed word. The first byte received sits in bits 31:24 and the fourth in bits 7:0. `push_o` and `push_word_o` appear one cycle after the fourth byte.
- R5: When a request ends on a partial word of k bytes (k = 1..3), that word is pushed one cycle after the last byte. Its valid bytes fill the low 8*k bits, the first-received byte is the most significant of them, and the upper bits are zero.
- R6: Bits 30:28 of `status_o` hold the number of valid bytes (1 to 4) in the most recently completed word. Bit 1 of `status_o` mirrors `run_o`.
- R7: A count write while `todo_o` is non-zero is ignored.
- R8: A new request written after an earlier one has finished starts a fresh word. Its first byte lands in the top valid byte of its first word.
- R9: A word that completes while `fifo_full_i` is high is not pushed, and bit 0 of `status_o` (overflow) is set. The flag stays set until an `err_clr_i` pulse clears it in the next cycle.
- R10: `sdo_o` always equals `idle_lvl_i`, including while bytes are being clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr_i | input | 1 | Write strobe for the byte count |
| req_count_i | input | 16 | Requested number of bytes |
| err_clr_i | input | 1 | Clears the sticky overflow flag |
| byte_vld_i | input | 1 | Shift engine delivers one received byte |
| byte_i | input | 8 | Received byte |
| fifo_full_i | input | 1 | Receive FIFO cannot take a word |
| idle_lvl_i | input | 1 | Idle level for the serial output |
| todo_o | output | 16 | Bytes still to be received |
| run_o | output | 1 | Serial clocking request to the shift engine |
| done_o | output | 1 | One-cycle pulse when a request completes |
| push_o | output | 1 | FIFO push strobe |
| push_word_o | output | 32 | Packed word for the FIFO |
| status_o | output | 32 | Bit 0 overflow, bit 1 running, bits 30:28 valid bytes |
| sdo_o | output | 1 | Serial data output |

## Verification
Directed requests of 4, 1, 7 and 6 bytes separate three cases: whole-word packing, a single-byte tail and multi-byte tails. Each one checks byte order and the valid-byte field. Random lengths from 1 to 40 bytes, with random gaps between strobes, show that packing and counting do not depend on when bytes arrive. Back-to-back chunks show that word alignment restarts with each request. Further cases cover a write while the block is busy, a zero count, a stray strobe while idle, and a full FIFO followed by an error clear. Together they confirm that requests are ignored while busy and that the overflow flag is sticky.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  // Status word layout
  localparam int STAT_W      = 32;
  localparam int STAT_OVF    = 0;
  localparam int STAT_RUN    = 1;
  localparam int STAT_VB_LSB = 28;
  localparam int STAT_VB_W   = 3;
endpackage

// File: rtl/rxo_count.sv
module rxo_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             take,
  output logic [CNT_W-1:0] todo,
  output logic             last,
  output logic             done
);
  logic [CNT_W-1:0] todo_q, todo_d;
  logic             done_q, done_d;
  logic             todo_en;

  assign last = (todo_q == CNT_W'(1));

  always_comb begin
    todo_d  = todo_q;
    todo_en = load | take;
    if (load)      todo_d = load_val;
    else if (take) todo_d = todo_q - CNT_W'(1);
    done_d  = take & last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      todo_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (todo_en) todo_q <= todo_d;
      done_q <= done_d;
    end
  end

  assign todo = todo_q;
  assign done = done_q;
endmodule

// File: rtl/rxo_pack.sv
module rxo_pack #(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  parameter int VB_W       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take,
  input  logic [BYTE_W-1:0]            byte_in,
  input  logic                         last,
  input  logic                         fifo_full,
  output logic                         fire,
  output logic [VB_W-1:0]              nvalid,
  output logic                         push,
  output logic [BYTE_W*WORD_BYTES-1:0] word
);
  localparam int WORD_W = BYTE_W * WORD_BYTES;
  localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] acc_q, acc_d, next_word;
  logic [WORD_W-1:0] word_q;
  logic              push_q, push_d;
  logic              word_en;

  always_comb begin
    if (idx_q == '0) next_word = WORD_W'(byte_in);
    else             next_word = {acc_q[WORD_W-BYTE_W-1:0], byte_in};
    fire    = take & ((idx_q == IDX_W'(WORD_BYTES-1)) | last);
    nvalid  = VB_W'(idx_q) + VB_W'(1);
    idx_d   = idx_q;
    acc_d   = acc_q;
    if (take) begin
      acc_d = next_word;
      idx_d = fire ? '0 : idx_q + IDX_W'(1);
    end
    push_d  = fire & ~fifo_full;
    word_en = push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      acc_q  <= '0;
      word_q <= '0;
      push_q <= 1'b0;
    end else begin
      if (take) begin
        idx_q <= idx_d;
        acc_q <= acc_d;
      end
      if (word_en) word_q <= next_word;
      push_q <= push_d;
    end
  end

  assign push = push_q;
  assign word = word_q;
endmodule

// File: rtl/rxo_flags.sv
module rxo_flags #(
  parameter int VB_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [VB_W-1:0] nvalid,
  input  logic            fifo_full,
  input  logic            err_clr,
  output logic [VB_W-1:0] vb,
  output logic            ovf
);
  logic [VB_W-1:0] vb_q;
  logic            ovf_q, ovf_d;

  always_comb begin
    ovf_d = (ovf_q & ~err_clr) | (fire & fifo_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (fire) vb_q <= nvalid;
      ovf_q <= ovf_d;
    end
  end

  assign vb  = vb_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/rxo_req_ctl.sv
module rxo_req_ctl
  import rxo_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_wr_i,
  input  logic [CNT_W-1:0]             req_count_i,
  input  logic                         err_clr_i,
  input  logic                         byte_vld_i,
  input  logic [BYTE_W-1:0]            byte_i,
  input  logic                         fifo_full_i,
  input  logic                         idle_lvl_i,
  output logic [CNT_W-1:0]             todo_o,
  output logic                         run_o,
  output logic                         done_o,
  output logic                         push_o,
  output logic [BYTE_W*WORD_BYTES-1:0] push_word_o,
  output logic [STAT_W-1:0]            status_o,
  output logic                         sdo_o
);
  localparam int VB_W = STAT_VB_W;

  logic [CNT_W-1:0] todo;
  logic             busy, take, load, last, fire;
  logic [VB_W-1:0]  nvalid, vb;
  logic             ovf;

  assign busy = (todo != '0);
  assign take = byte_vld_i & busy;
  assign load = req_wr_i & ~busy;

  rxo_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(req_count_i),
    .take(take), .todo(todo), .last(last), .done(done_o)
  );

  rxo_pack #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .VB_W(VB_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(byte_i), .last(last),
    .fifo_full(fifo_full_i), .fire(fire), .nvalid(nvalid),
    .push(push_o), .word(push_word_o)
  );

  rxo_flags #(.VB_W(VB_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .fire(fire), .nvalid(nvalid),
    .fifo_full(fifo_full_i), .err_clr(err_clr_i), .vb(vb), .ovf(ovf)
  );

  always_comb begin
    status_o = '0;
    status_o[STAT_VB_LSB +: STAT_VB_W] = vb;
    status_o[STAT_RUN] = busy;
    status_o[STAT_OVF] = ovf;
  end

  assign todo_o = todo;
  assign run_o  = busy;
  assign sdo_o  = idle_lvl_i;
endmodule

// File: rtl/rxo_req_chk.sv
module rxo_req_chk #(
  parameter int CNT_W      = 16,
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_wr_i,
  input logic [CNT_W-1:0]             req_count_i,
  input logic                         err_clr_i,
  input logic                         byte_vld_i,
  input logic                         fifo_full_i,
  input logic [CNT_W-1:0]             todo_o,
  input logic                         run_o,
  input logic                         done_o,
  input logic                         push_o,
  input logic [31:0]                  status_o
);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr_i && todo_o == '0) |=> (todo_o == $past(req_count_i)));

  // R3
  todo_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && todo_o != '0) |=> (todo_o == $past(todo_o) - CNT_W'(1)));

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (todo_o == '0 && !run_o));

  // R7
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr_i && todo_o != '0 && !byte_vld_i) |=> $stable(todo_o));

  // R9
  no_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> !$past(fifo_full_i));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && !err_clr_i) |=> status_o[0]);

  // R6
  vb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (status_o[30:28] >= 3'd1 && status_o[30:28] <= 3'(WORD_BYTES)));
endmodule

bind rxo_req_ctl rxo_req_chk #(
  .CNT_W(CNT_W), .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_wr_i(req_wr_i), .req_count_i(req_count_i),
  .err_clr_i(err_clr_i), .byte_vld_i(byte_vld_i), .fifo_full_i(fifo_full_i),
  .todo_o(todo_o), .run_o(run_o), .done_o(done_o), .push_o(push_o),
  .status_o(status_o)
);

// File: tb/rxo_req_ctl_tb.sv
module rxo_req_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_wr, err_clr, byte_vld, fifo_full, idle_lvl;
  logic [15:0] req_count;
  logic [7:0]  byte_in;
  logic [15:0] todo;
  logic        run, done, push, sdo;
  logic [31:0] push_word, status;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] got [0:63];
  int gcnt = 0;

  always #10 clk = ~clk;

  rxo_req_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_wr_i(req_wr), .req_count_i(req_count),
    .err_clr_i(err_clr), .byte_vld_i(byte_vld), .byte_i(byte_in),
    .fifo_full_i(fifo_full), .idle_lvl_i(idle_lvl), .todo_o(todo),
    .run_o(run), .done_o(done), .push_o(push), .push_word_o(push_word),
    .status_o(status), .sdo_o(sdo)
  );

  always @(negedge clk) begin
    if (rst_n && push) begin
      if (gcnt < 64) got[gcnt] = push_word;
      gcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_byte(input logic [31:0] acc, input int k,
                                            input logic [7:0] b);
    if (k == 0) return {24'h0, b};
    return {acc[23:0], b};
  endfunction

  task automatic run_req(input int n, input bit full_on, input bit poke,
                         input string wtag);
    logic [31:0] exp_w [0:63];
    int          exp_k [0:63];
    int          ecnt = 0;
    logic [31:0] acc = '0;
    int          k = 0;
    int          exp_vb = 0;
    gcnt = 0;
    fifo_full = full_on;
    req_wr = 1'b1;
    req_count = n[15:0];
    @(negedge clk);
    req_wr = 1'b0;
    chk(todo == n[15:0], "R2", 32'(todo), n);
    chk(run == (n != 0), "R2", 32'(run), 32'(n != 0));
    for (int i = 0; i < n; i++) begin
      int gap = $urandom_range(0, 2);
      logic [7:0] b;
      repeat (gap) @(negedge clk);
      b = 8'($urandom);
      byte_vld = 1'b1;
      byte_in = b;
      if (poke && i == 1) begin
        req_wr = 1'b1;
        req_count = 16'h03FF;
      end
      acc = pack_byte(acc, k, b);
      k++;
      if (k == 4 || i == n - 1) begin
        exp_w[ecnt] = acc;
        exp_k[ecnt] = k;
        ecnt++;
        exp_vb = k;
        k = 0;
      end
      chk(sdo == idle_lvl, "R10", 32'(sdo), 32'(idle_lvl));
      @(negedge clk);
      byte_vld = 1'b0;
      if (poke && i == 1) begin
        req_wr = 1'b0;
        chk(todo == 16'(n - 2), "R7", 32'(todo), n - 2);
      end
      chk(todo == 16'(n - i - 1), "R3", 32'(todo), n - i - 1);
    end
    chk(done == (n != 0), "R3", 32'(done), 32'(n != 0));
    chk(run == 1'b0, "R3", 32'(run), 0);
    @(negedge clk);
    chk(done == 1'b0, "R3", 32'(done), 0);
    if (!full_on) begin
      chk(gcnt == ecnt, wtag, gcnt, ecnt);
      for (int j = 0; j < ecnt && j < gcnt; j++)
        chk(got[j] == exp_w[j], (exp_k[j] == 4) ? wtag : "R5", got[j], exp_w[j]);
      if (n > 0)
        chk(status[30:28] == 3'(exp_vb), "R6", 32'(status[30:28]), exp_vb);
    end else begin
      chk(gcnt == 0, "R9", gcnt, 0);
      chk(status[0] == 1'b1, "R9", 32'(status[0]), 1);
    end
    fifo_full = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    req_wr = 0; req_count = 0; err_clr = 0; byte_vld = 0; byte_in = 0;
    fifo_full = 0; idle_lvl = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(todo == 0, "R1", 32'(todo), 0);
    chk(run == 0 && done == 0 && push == 0, "R1", {29'h0, run, done, push}, 0);
    chk(status == 0, "R1", status, 0);

    // Directed packing cases
    run_req(4, 0, 0, "R4");
    run_req(1, 0, 0, "R4");
    run_req(7, 0, 0, "R4");
    idle_lvl = 1'b0;
    run_req(6, 0, 0, "R4");

    // R2 zero count starts nothing
    req_wr = 1; req_count = 0;
    @(negedge clk);
    req_wr = 0;
    chk(todo == 0 && run == 0, "R2", {15'h0, run, todo}, 0);

    // R3 stray strobe while idle
    gcnt = 0;
    byte_vld = 1; byte_in = 8'hA5;
    @(negedge clk);
    byte_vld = 0;
    @(negedge clk);
    chk(gcnt == 0 && todo == 0, "R3", {16'(gcnt), todo}, 0);

    // R7 write while busy
    run_req(5, 0, 1, "R4");

    // R8 chunked receive
    run_req(6, 0, 0, "R8");
    run_req(6, 0, 0, "R8");

    // Random lengths
    for (int r = 0; r < 10; r++) begin
      idle_lvl = 1'($urandom);
      run_req($urandom_range(1, 40), 0, 0, "R4");
    end

    // R9 overflow and sticky flag
    run_req(4, 1, 0, "R9");
    run_req(4, 0, 0, "R4");
    chk(status[0] == 1'b1, "R9", 32'(status[0]), 1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk(status[0] == 1'b0, "R9", 32'(status[0]), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule